// File: doc/BRIEF.md
# Staged Two-Way Multiplexer Switch Controller

This block owns the open/closed state of twelve switches arranged as six two-input multiplexers. Each multiplexer has an A-side switch and a B-side switch. A serial front end hands the block one decoded command byte at a time. With each byte come two flags: a load flag and a run flag. The run flag is active high; driving it low clears the block.

Commands first edit a staged (shadow) copy of the switch state. The live switch outputs change only when a command arrives with its load flag set. That command is itself applied to the staged copy before the copy is committed.

A commit never closes and opens switches on the same edge. Every switch that must open is opened at once, and the switches that must close follow a parameterised number of cycles later. The block also assembles a 16-bit readback word from the live switch state.

Top module: `mux_stage_ctrl`

## Requirements
- R1: Asynchronous reset, or a command accepted with the run flag at 0, opens every live switch and clears the staged copy. The live outputs and the status word read 0 from the edge that accepts the command. A later load of a command that changes nothing still leaves every switch open.
- R2: For a switch command, the command byte fields are:
  - bit 7 is the close (1) or open (0) value;
  - bits 6:5 are 00;
  - bits 4:1 are the target: 0 means every multiplexer, 1 to 6 mean multiplexer 1 to 6;
  - bit 0 picks side A (0) or side B (1).
  
  These are the codes 0 to 13 in bits 4:0.
- R3: Closing one side of a multiplexer in the staged copy opens the other side of that multiplexer.
- R4: Group-clear codes ignore bit 7:
  - codes 14 to 19 in bits 4:0 open both switches of multiplexer 1 to 6 (code minus 13);
  - code 31 with bit 7 at 0 opens every switch.
- R5: These commands are reserved and leave the staged copy unchanged:
  - code 20 to 30;
  - code 31 with bit 7 at 1;
  - any byte with bits 6:5 not 00.
- R6: A command without the load flag does not change the live outputs.
- R7: A command with the load flag commits every command staged since the previous load, together with its own. When several staged commands hit the same switch, the last one wins.
- R8: On a commit, switches that open do so at the accepting edge. Switches that close do so BBM_GAP cycles later, and no edge both opens and closes switches. No multiplexer ever has both live switches closed.
- R9: The status word reports live switches in bits 15 down to 4, in the order S1A, S1B, S2A, S2B through S6A, S6B, where a 1 means closed. Bits 3:0 read 0.
- R10: The status word reflects the live outputs, never the staged copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command byte and flags are valid this cycle |
| cmd_byte_i | input | 8 | Decoded command byte |
| cmd_load_i | input | 1 | Commit the staged copy after applying this command |
| cmd_run_i | input | 1 | 1 for normal operation, 0 clears all switches |
| sw_a_o | output | 6 | Live A-side switch per multiplexer, 1 = closed |
| sw_b_o | output | 6 | Live B-side switch per multiplexer, 1 = closed |
| status_o | output | 16 | Readback word of the live switch state |

## Verification
The assertions assume that the front end presents a command for exactly one cycle and that the run flag is high whenever no clear is intended. They also assume that BBM_GAP is at least one.

The stimulus drives every command as a single-cycle pulse. It returns the load flag to 0 and the run flag to 1 in between. It lets each commit finish its close delay before the next command, except where a later load is meant to overlap.

Bits 6:5 are held at 00 except when a reserved pattern is the point of the test.

// File: rtl/mux_ctrl_pkg.sv
package mux_ctrl_pkg;

  localparam int CMD_W = 8;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    OP_SWITCH   = 2'd0,
    OP_DISABLE  = 2'd1,
    OP_ALL_OPEN = 2'd2,
    OP_RESERVED = 2'd3
  } op_kind_e;

  typedef struct packed {
    op_kind_e         kind;
    logic             close;
    logic             side_b;
    logic             all_mux;
    logic [SEL_W-1:0] target;
  } cmd_dec_t;

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n_o = sync_q[1];

endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import mux_ctrl_pkg::*;
#(
  parameter int NUM_MUX = 6
) (
  input  logic [CMD_W-1:0] cmd_i,
  output cmd_dec_t         dec_o
);

  localparam int DIS_BASE  = 2 * (NUM_MUX + 1);
  localparam int DIS_LAST  = DIS_BASE + NUM_MUX - 1;
  localparam int CLR_CODE  = 31;

  logic [4:0] code;
  logic [4:0] dis_off;

  always_comb begin
    code         = cmd_i[4:0];
    dis_off      = code - 5'(DIS_BASE);
    dec_o.close  = cmd_i[7];
    dec_o.side_b = cmd_i[0];
    dec_o.all_mux = 1'b0;
    dec_o.target = '0;
    dec_o.kind   = OP_RESERVED;
    if (cmd_i[6:5] != 2'b00) begin
      dec_o.kind = OP_RESERVED;
    end else if (code < 5'(DIS_BASE)) begin
      dec_o.kind    = OP_SWITCH;
      dec_o.target  = cmd_i[4:1];
      dec_o.all_mux = (cmd_i[4:1] == '0);
    end else if (code <= 5'(DIS_LAST)) begin
      dec_o.kind   = OP_DISABLE;
      dec_o.target = SEL_W'(dis_off) + SEL_W'(1);
    end else if ((code == 5'(CLR_CODE)) && !cmd_i[7]) begin
      dec_o.kind = OP_ALL_OPEN;
    end
  end

endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import mux_ctrl_pkg::*;
#(
  parameter int NUM_MUX = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 upd_i,
  input  cmd_dec_t             dec_i,
  output logic [2*NUM_MUX-1:0] shadow_o,
  output logic [2*NUM_MUX-1:0] next_o
);

  localparam int SW_N = 2 * NUM_MUX;

  logic [SW_N-1:0] shadow_q;
  logic [SW_N-1:0] shadow_d;

  for (genvar m = 0; m < NUM_MUX; m++) begin : g_mux
    logic hit, wipe, na, nb;

    always_comb begin
      hit  = (dec_i.kind == OP_SWITCH) &&
             (dec_i.all_mux || (dec_i.target == SEL_W'(m + 1)));
      wipe = (dec_i.kind == OP_ALL_OPEN) ||
             ((dec_i.kind == OP_DISABLE) && (dec_i.target == SEL_W'(m + 1)));
      na   = shadow_q[2*m];
      nb   = shadow_q[2*m+1];
      if (wipe) begin
        na = 1'b0;
        nb = 1'b0;
      end else if (hit) begin
        if (dec_i.side_b) begin
          nb = dec_i.close;
          if (dec_i.close) na = 1'b0;
        end else begin
          na = dec_i.close;
          if (dec_i.close) nb = 1'b0;
        end
      end
    end

    assign next_o[2*m]   = na;
    assign next_o[2*m+1] = nb;

    p_shadow_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(shadow_q[2*m] && shadow_q[2*m+1]));
  end

  always_comb begin
    shadow_d = shadow_q;
    if (clr_i) begin
      shadow_d = '0;
    end else if (upd_i) begin
      shadow_d = next_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else begin
      shadow_q <= shadow_d;
    end
  end

  assign shadow_o = shadow_q;

  p_rsvd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !clr_i && (dec_i.kind == OP_RESERVED)) |=> (shadow_q == $past(shadow_q)));

  p_clear_shadow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (shadow_q == '0));

endmodule

// File: rtl/commit_seq.sv
module commit_seq #(
  parameter int SW_N    = 12,
  parameter int BBM_GAP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            commit_i,
  input  logic [SW_N-1:0] target_i,
  output logic [SW_N-1:0] live_o
);

  localparam int CNT_W = (BBM_GAP > 1) ? $clog2(BBM_GAP) : 1;

  logic [SW_N-1:0]  live_q, live_d;
  logic [SW_N-1:0]  pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    live_d = live_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (clr_i) begin
      live_d = '0;
      pend_d = '0;
      cnt_d  = '0;
      busy_d = 1'b0;
    end else if (commit_i) begin
      live_d = live_q & target_i;
      pend_d = target_i;
      cnt_d  = CNT_W'(BBM_GAP - 1);
      busy_d = |(target_i & ~live_q);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        live_d = pend_q;
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      pend_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      live_q <= live_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign live_o = live_q;

  p_no_mixed_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !((|(live_q & ~$past(live_q))) && (|(~live_q & $past(live_q)))));

  p_close_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !clr_i) |=> ((live_q & ~$past(live_q)) == '0));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_i && !clr_i && !busy_q) |=> $stable(live_q));

  p_clear_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (live_q == '0));

  for (genvar m = 0; m < SW_N / 2; m++) begin : g_excl
    p_live_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(live_q[2*m] && live_q[2*m+1]));
  end

endmodule

// File: rtl/mux_stage_ctrl.sv
module mux_stage_ctrl
  import mux_ctrl_pkg::*;
#(
  parameter int NUM_MUX = 6,
  parameter int BBM_GAP = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cmd_valid_i,
  input  logic [7:0]                         cmd_byte_i,
  input  logic                               cmd_load_i,
  input  logic                               cmd_run_i,
  output logic [NUM_MUX-1:0]                 sw_a_o,
  output logic [NUM_MUX-1:0]                 sw_b_o,
  output logic [((2*NUM_MUX+7)/8)*8-1:0]     status_o
);

  localparam int SW_N   = 2 * NUM_MUX;
  localparam int STAT_W = ((SW_N + 7) / 8) * 8;

  logic            srst_n;
  cmd_dec_t        dec;
  logic            clr, upd, commit;
  logic [SW_N-1:0] shadow, shadow_next, live;

  rst_sync u_rst_sync (
    .clk      (clk),
    .arst_n   (rst_n),
    .srst_n_o (srst_n)
  );

  cmd_decode #(.NUM_MUX(NUM_MUX)) u_decode (
    .cmd_i (cmd_byte_i),
    .dec_o (dec)
  );

  assign clr    = cmd_valid_i && !cmd_run_i;
  assign upd    = cmd_valid_i &&  cmd_run_i;
  assign commit = upd && cmd_load_i;

  shadow_bank #(.NUM_MUX(NUM_MUX)) u_shadow (
    .clk      (clk),
    .rst_n    (srst_n),
    .clr_i    (clr),
    .upd_i    (upd),
    .dec_i    (dec),
    .shadow_o (shadow),
    .next_o   (shadow_next)
  );

  commit_seq #(.SW_N(SW_N), .BBM_GAP(BBM_GAP)) u_commit (
    .clk      (clk),
    .rst_n    (srst_n),
    .clr_i    (clr),
    .commit_i (commit),
    .target_i (shadow_next),
    .live_o   (live)
  );

  for (genvar m = 0; m < NUM_MUX; m++) begin : g_out
    assign sw_a_o[m] = live[2*m];
    assign sw_b_o[m] = live[2*m+1];
  end

  for (genvar k = 0; k < SW_N; k++) begin : g_stat
    assign status_o[STAT_W-1-k] = live[k];
  end

  if (STAT_W > SW_N) begin : g_pad
    assign status_o[STAT_W-SW_N-1:0] = '0;
  end

  p_load_follows_shadow_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (commit && !clr) |=> ((live & ~shadow) == '0));

endmodule

// File: tb/mux_stage_ctrl_tb_top.sv
module mux_stage_ctrl_tb_top;

  localparam int GAP  = 2;
  localparam int NMUX = 6;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [7:0]  cmd_byte;
  logic        cmd_load;
  logic        cmd_run;
  logic [5:0]  sw_a, sw_b;
  logic [15:0] status;

  int n_checks = 0;
  int n_errors = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  logic [11:0] m_sh   = '0;
  logic [11:0] m_live = '0;

  mux_stage_ctrl #(.NUM_MUX(NMUX), .BBM_GAP(GAP)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_byte_i  (cmd_byte),
    .cmd_load_i  (cmd_load),
    .cmd_run_i   (cmd_run),
    .sw_a_o      (sw_a),
    .sw_b_o      (sw_b),
    .status_o    (status)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [11:0] live_now();
    logic [11:0] v;
    for (int m = 0; m < 6; m++) begin
      v[2*m]   = sw_a[m];
      v[2*m+1] = sw_b[m];
    end
    return v;
  endfunction

  function automatic logic [15:0] to_status(input logic [11:0] v);
    logic [15:0] s = '0;
    for (int k = 0; k < 12; k++) s[15-k] = v[k];
    return s;
  endfunction

  function automatic logic [11:0] apply(input logic [7:0] b, input logic [11:0] sh);
    logic [11:0] r = sh;
    int code = int'(b[4:0]);
    if (b[6:5] != 2'b00) return r;
    if (code <= 13) begin
      int t = code / 2;
      int s = code % 2;
      for (int m = 0; m < 6; m++) begin
        if (t == 0 || t == m + 1) begin
          if (b[7]) begin
            r[2*m+s]     = 1'b1;
            r[2*m+1-s]   = 1'b0;
          end else begin
            r[2*m+s]     = 1'b0;
          end
        end
      end
    end else if (code <= 19) begin
      r[2*(code-14)]   = 1'b0;
      r[2*(code-14)+1] = 1'b0;
    end else if (code == 31 && !b[7]) begin
      r = '0;
    end
    return r;
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares status against queued expectations.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string       t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(status === e, t, status, e);
    end
  end

  task automatic send(input logic [7:0] b, input logic ld, input logic rb, input string tag);
    logic [11:0] old_live, want_open;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = b; cmd_load = ld; cmd_run = rb;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_load = 1'b0; cmd_run = 1'b1;
    old_live = m_live;
    if (!rb) begin
      m_sh = '0; m_live = '0;
    end else begin
      m_sh = apply(b, m_sh);
      if (ld) m_live = m_sh;
    end
    want_open = !rb ? 12'h000 : (ld ? (old_live & m_live) : old_live);
    check(live_now() == want_open, ld ? "R8 open phase" : (rb ? "R6 no load" : "R1 clear"),
          {4'h0, live_now()}, {4'h0, want_open});
    for (int i = 1; i < GAP; i++) begin
      @(negedge clk);
      check(live_now() == want_open, "R8 close delay", {4'h0, live_now()}, {4'h0, want_open});
    end
    @(negedge clk);
    check(((live_now() & (live_now() >> 1)) & 12'h555) == '0, "R8 exclusive",
          {4'h0, live_now()}, 16'h0);
    exp_q.push_back(to_status(m_live));
    tag_q.push_back(tag);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_byte = '0; cmd_load = 1'b0; cmd_run = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(status == 16'h0 && sw_a == '0 && sw_b == '0, "R1 reset", status, 16'h0);

    send(8'h82, 1'b1, 1'b1, "R2 R9 close S1A");
    check(status == 16'h8000, "R9 S1A bit 15", status, 16'h8000);
    check(status[3:0] == 4'h0, "R9 pad bits", {12'h0, status[3:0]}, 16'h0);
    send(8'h87, 1'b0, 1'b1, "R6 R10 staged S3B");
    send(8'h8C, 1'b1, 1'b1, "R7 joint commit");
    check(status == 16'h8420, "R7 joint commit", status, 16'h8420);
    send(8'h85, 1'b0, 1'b1, "R6 staged S2B");
    send(8'h05, 1'b1, 1'b1, "R7 last wins");
    send(8'h83, 1'b1, 1'b1, "R3 R8 swap mux1");
    send(8'h80, 1'b1, 1'b1, "R2 R3 all A");
    send(8'h81, 1'b1, 1'b1, "R2 R8 all B");
    send(8'h90, 1'b1, 1'b1, "R4 disable mux3");
    send(8'h0E, 1'b1, 1'b1, "R4 disable mux1");
    send(8'h94, 1'b1, 1'b1, "R5 code 20");
    send(8'h9F, 1'b1, 1'b1, "R5 code 31 close");
    send(8'hA2, 1'b1, 1'b1, "R5 bits 6:5");
    send(8'h1F, 1'b1, 1'b1, "R4 all open");
    check(status == 16'h0, "R4 all open", status, 16'h0);
    send(8'h82, 1'b1, 1'b1, "R2 close S1A");
    send(8'h87, 1'b0, 1'b1, "R6 staged S3B");
    send(8'h00, 1'b0, 1'b0, "R1 soft clear");
    send(8'h94, 1'b1, 1'b1, "R1 shadow cleared");
    send(8'h8B, 1'b1, 1'b1, "R2 close S5B");
    send(8'h88, 1'b0, 1'b1, "R10 staged S4A");
    check(status == 16'h0040, "R10 live only", status, 16'h0040);

    repeat (4) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule